// File: doc/BRIEF.md
# Pointer Register Literal Adjust Unit

This block holds three 12-bit indirect pointer registers and runs the pointer-arithmetic instructions of a small processor core on them. Each accepted 16-bit instruction word is decoded. The block then adds or subtracts a 6-bit unsigned literal on one pointer, or pushes an 8-bit literal to data memory through pointer 2. It leaves every status flag alone.

When the 2-bit pointer select field holds 3, the arithmetic is applied to pointer 2 and a return is requested from a separate return-stack unit. That form takes two cycles. During the second cycle the block raises a flush so that the fetch stage discards the instruction it has already fetched. The push instruction writes its literal at the address held in pointer 2 and decrements pointer 2 in the same cycle.

A plain load port lets the surrounding core set any pointer directly. All outputs are registered.

Top module: `ptr_adjust_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all three pointers read 0 and `mem_we`, `ret_req` and `flush` are low.
- R2: An accepted word whose upper byte is 0xE8 adds bits [5:0] (unsigned, 0 to 63) to the pointer chosen by bits [7:6] (0, 1 or 2). The new value shows on `ptr_o` in the cycle after acceptance, and the instruction needs only that one cycle.
- R3: An accepted word whose upper byte is 0xE9 subtracts bits [5:0] from the pointer chosen by bits [7:6], with the same timing as R2.
- R4: All pointer arithmetic wraps modulo 4096.
- R5: When bits [7:6] equal 3 in an add or subtract word, the operation is applied to pointer 2. `ret_req` and `flush` are then both high for exactly the one cycle after acceptance.
- R6: While `flush` is high, `instr_valid` is ignored, and an instruction presented in that cycle changes no pointer.
- R7: An accepted word whose upper byte is 0xFA raises `mem_we` for exactly one cycle. In that cycle `mem_addr` holds the old pointer 2 and `mem_wdata` holds bits [7:0], and pointer 2 reads its old value minus 1.
- R8: A word with any other upper byte, or any word presented with `instr_valid` low, changes no pointer and raises no `mem_we` or `ret_req`.
- R9: `ptr_ld` with `ptr_ld_sel` 0 to 2 writes `ptr_ld_val` into that pointer on the next edge. For that pointer it takes priority over an instruction in the same cycle. A `ptr_ld_sel` of 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is present |
| instr | input | 16 | Instruction word |
| ptr_ld | input | 1 | Direct pointer load strobe |
| ptr_ld_sel | input | 2 | Pointer index for the load |
| ptr_ld_val | input | 12 | Value to load |
| ptr_o | output | 36 | Pointers 2, 1, 0 packed, pointer 0 in bits [11:0] |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 12 | Data memory write address |
| mem_wdata | output | 8 | Data memory write data |
| ret_req | output | 1 | One-cycle return request |
| flush | output | 1 | Bubble cycle, fetched instruction to be discarded |

## Verification
The assertions assume that reset is held for at least two edges at start-up. The pointer-2 check after a push also assumes that no direct load of pointer 2 coincides with that push, and it is gated off if one does. The assertions further assume that the core does not count on `instr_valid` being honoured during a flush cycle. The stimulus loads pointers only on idle cycles or in deliberate priority tests. It holds reset for several edges, and it presents an instruction during a bubble only to show that the instruction is dropped.

// File: rtl/ptr_adjust_pkg.sv
package ptr_adjust_pkg;

  localparam int unsigned DEF_PTR_W   = 12;
  localparam int unsigned DEF_INSTR_W = 16;
  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned DEF_LIT_W   = 6;
  localparam int unsigned DEF_NUM_PTR = 3;

  // Upper-byte opcode values
  localparam logic [7:0] OPC_ADD  = 8'hE8;
  localparam logic [7:0] OPC_SUB  = 8'hE9;
  localparam logic [7:0] OPC_PUSH = 8'hFA;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_PUSH = 2'd3
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] tgt;   // pointer actually updated
    logic       ret;   // return form
    logic [7:0] lit;   // raw low byte
  } dec_t;

endpackage

// File: rtl/ptr_decode.sv
module ptr_decode
  import ptr_adjust_pkg::*;
#(
  parameter int unsigned INSTR_W = DEF_INSTR_W
) (
  input  logic               valid,
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);

  localparam int unsigned HI = INSTR_W - 1;

  logic [7:0] opc;
  logic [1:0] sel;

  assign opc = instr[HI -: 8];
  assign sel = instr[7:6];

  always_comb begin
    dec.op  = OP_NONE;
    dec.tgt = 2'd0;
    dec.ret = 1'b0;
    dec.lit = instr[7:0];
    if (valid) begin
      unique case (opc)
        OPC_ADD, OPC_SUB: begin
          dec.op  = (opc == OPC_ADD) ? OP_ADD : OP_SUB;
          dec.ret = (sel == 2'd3);
          dec.tgt = (sel == 2'd3) ? 2'd2 : sel;
        end
        OPC_PUSH: begin
          dec.op  = OP_PUSH;
          dec.tgt = 2'd2;
        end
        default: dec.op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ptr_file.sv
module ptr_file #(
  parameter int unsigned NUM_PTR = 3,
  parameter int unsigned PTR_W   = 12,
  localparam int unsigned SEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           op_en,
  input  logic [SEL_W-1:0]               op_sel,
  input  logic                           op_sub,
  input  logic [PTR_W-1:0]               op_amt,
  input  logic                           ld_en,
  input  logic [SEL_W-1:0]               ld_sel,
  input  logic [PTR_W-1:0]               ld_val,
  output logic [NUM_PTR-1:0][PTR_W-1:0]  ptrs
);

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic             hit_op;
    logic             hit_ld;
    logic [PTR_W-1:0] arith;

    assign hit_op = op_en && (op_sel == SEL_W'(g));
    assign hit_ld = ld_en && (ld_sel == SEL_W'(g));
    assign arith  = op_sub ? (ptrs[g] - op_amt) : (ptrs[g] + op_amt);

    always_ff @(posedge clk) begin
      if (rst)         ptrs[g] <= '0;
      else if (hit_ld) ptrs[g] <= ld_val;
      else if (hit_op) ptrs[g] <= arith;
    end
  end

  // R9
  ld_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && (ld_sel < SEL_W'(NUM_PTR))) |=> (ptrs[$past(ld_sel)] == $past(ld_val)));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_en && !ld_en) |=> $stable(ptrs));

endmodule

// File: rtl/ptr_adjust_unit.sv
module ptr_adjust_unit
  import ptr_adjust_pkg::*;
#(
  parameter int unsigned PTR_W   = DEF_PTR_W,
  parameter int unsigned INSTR_W = DEF_INSTR_W,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned LIT_W   = DEF_LIT_W,
  parameter int unsigned NUM_PTR = DEF_NUM_PTR
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       instr_valid,
  input  logic [INSTR_W-1:0]         instr,
  input  logic                       ptr_ld,
  input  logic [1:0]                 ptr_ld_sel,
  input  logic [PTR_W-1:0]           ptr_ld_val,
  output logic [NUM_PTR*PTR_W-1:0]   ptr_o,
  output logic                       mem_we,
  output logic [PTR_W-1:0]           mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic                       ret_req,
  output logic                       flush
);

  localparam int unsigned PUSH_PTR = 2;

  dec_t                          dec;
  logic                          accept;
  logic                          op_en;
  logic [PTR_W-1:0]              op_amt;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptrs;

  assign accept = instr_valid && !flush;

  ptr_decode #(.INSTR_W(INSTR_W)) u_dec (
    .valid (accept),
    .instr (instr),
    .dec   (dec)
  );

  assign op_en  = (dec.op != OP_NONE);
  assign op_amt = (dec.op == OP_PUSH) ? PTR_W'(1) : PTR_W'(dec.lit[LIT_W-1:0]);

  ptr_file #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) u_file (
    .clk    (clk),
    .rst    (rst),
    .op_en  (op_en),
    .op_sel (dec.tgt),
    .op_sub (dec.op != OP_ADD),
    .op_amt (op_amt),
    .ld_en  (ptr_ld),
    .ld_sel (ptr_ld_sel),
    .ld_val (ptr_ld_val),
    .ptrs   (ptrs)
  );

  assign ptr_o = ptrs;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ret_req   <= 1'b0;
      flush     <= 1'b0;
    end else begin
      mem_we  <= (dec.op == OP_PUSH);
      ret_req <= op_en && dec.ret;
      flush   <= op_en && dec.ret;
      if (dec.op == OP_PUSH) begin
        mem_addr  <= ptrs[PUSH_PTR];
        mem_wdata <= dec.lit[DATA_W-1:0];
      end
    end
  end

  // R5
  ret_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ret_req |=> !ret_req);

  // R5
  ret_flush_chk: assert property (@(posedge clk) disable iff (rst)
    ret_req |-> flush);

  // R6
  bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && !ptr_ld) |=> $stable(ptr_o));

  // R7
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !$past(ptr_ld && ptr_ld_sel == 2'd2)) |-> (ptrs[PUSH_PTR] == mem_addr - PTR_W'(1)));

  // R7
  push_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !flush);

  // R8
  unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && dec.op == OP_NONE) |=> (!mem_we && !ret_req));

endmodule

// File: tb/ptr_adjust_unit_test.sv
module ptr_adjust_unit_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic [15:0] instr;
  logic        ptr_ld;
  logic [1:0]  ptr_ld_sel;
  logic [11:0] ptr_ld_val;
  logic [35:0] ptr_o;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        ret_req;
  logic        flush;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ptr_adjust_unit uut (
    .clk, .rst, .instr_valid, .instr, .ptr_ld, .ptr_ld_sel, .ptr_ld_val,
    .ptr_o, .mem_we, .mem_addr, .mem_wdata, .ret_req, .flush
  );

  typedef struct packed {
    logic [15:0] ins;
    logic [11:0] p0;
    logic [11:0] p1;
    logic [11:0] p2;
    logic        we;
    logic [11:0] addr;
    logic [7:0]  data;
    logic        ret;
  } vec_t;

  // Start state: p0=3FF, p1=010, p2=1EC
  localparam vec_t VEC [0:9] = '{
    '{16'hE823, 12'h422, 12'h010, 12'h1EC, 1'b0, 12'h000, 8'h00, 1'b0}, // R2
    '{16'hE945, 12'h422, 12'h00B, 12'h1EC, 1'b0, 12'h000, 8'h00, 1'b0}, // R3
    '{16'hFA08, 12'h422, 12'h00B, 12'h1EB, 1'b1, 12'h1EC, 8'h08, 1'b0}, // R7
    '{16'hE8D5, 12'h422, 12'h00B, 12'h200, 1'b0, 12'h000, 8'h00, 1'b1}, // R5
    '{16'hE9FF, 12'h422, 12'h00B, 12'h1C1, 1'b0, 12'h000, 8'h00, 1'b1}, // R5
    '{16'hE93F, 12'h3E3, 12'h00B, 12'h1C1, 1'b0, 12'h000, 8'h00, 1'b0}, // R3
    '{16'h1234, 12'h3E3, 12'h00B, 12'h1C1, 1'b0, 12'h000, 8'h00, 1'b0}, // R8
    '{16'hE880, 12'h3E3, 12'h00B, 12'h1C1, 1'b0, 12'h000, 8'h00, 1'b0}, // R2
    '{16'hFB12, 12'h3E3, 12'h00B, 12'h1C1, 1'b0, 12'h000, 8'h00, 1'b0}, // R8
    '{16'hFAFF, 12'h3E3, 12'h00B, 12'h1C0, 1'b1, 12'h1C1, 8'hFF, 1'b0}  // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] sel, input logic [11:0] val);
    @(negedge clk);
    ptr_ld = 1'b1; ptr_ld_sel = sel; ptr_ld_val = val;
    @(negedge clk);
    ptr_ld = 1'b0;
  endtask

  // Present one word for one edge; return sampled at following negedge
  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    instr_valid = 1'b1; instr = w;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; instr = '0;
    ptr_ld = 1'b0; ptr_ld_sel = '0; ptr_ld_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ptrs", ptr_o, 36'h0);
    chk("R1 we/ret/flush", {mem_we, ret_req, flush}, 3'b000);

    load(2'd0, 12'h3FF);
    load(2'd1, 12'h010);
    load(2'd2, 12'h1EC);

    foreach (VEC[i]) begin
      issue(VEC[i].ins);
      chk($sformatf("R2/R3/R8 vec%0d p0", i), ptr_o[11:0],  VEC[i].p0);
      chk($sformatf("R2/R3/R8 vec%0d p1", i), ptr_o[23:12], VEC[i].p1);
      chk($sformatf("R5/R7 vec%0d p2", i),    ptr_o[35:24], VEC[i].p2);
      chk($sformatf("R7 vec%0d we", i), mem_we, VEC[i].we);
      if (VEC[i].we) begin
        chk($sformatf("R7 vec%0d addr", i), mem_addr, VEC[i].addr);
        chk($sformatf("R7 vec%0d data", i), mem_wdata, VEC[i].data);
      end
      chk($sformatf("R5 vec%0d ret", i), ret_req, VEC[i].ret);
      chk($sformatf("R5 vec%0d flush", i), flush, VEC[i].ret);
      @(negedge clk);
      chk($sformatf("R5/R7 vec%0d pulse end", i), {mem_we, ret_req, flush}, 3'b000);
    end

    // R4 wrap on add, subtract and push
    load(2'd1, 12'hFF0);
    issue(16'hE87F);
    chk("R4 add wrap", ptr_o[23:12], 12'h02F);
    load(2'd0, 12'h005);
    issue(16'hE910);
    chk("R4 sub wrap", ptr_o[11:0], 12'hFF5);
    load(2'd2, 12'h000);
    issue(16'hFA5A);
    chk("R4 push wrap p2", ptr_o[35:24], 12'hFFF);
    chk("R7 push addr 0", mem_addr, 12'h000);

    // R6 instruction presented in the bubble is dropped
    load(2'd0, 12'h100);
    @(negedge clk);
    instr_valid = 1'b1; instr = 16'hE8C1;
    @(negedge clk);
    chk("R5 flush raised", flush, 1'b1);
    instr = 16'hE801;
    @(negedge clk);
    instr_valid = 1'b0;
    chk("R6 bubble drop p0", ptr_o[11:0], 12'h100);
    chk("R5 p2 incremented", ptr_o[35:24], 12'h000);
    chk("R6 flush cleared", flush, 1'b0);

    // R9 load priority and ignored select
    @(negedge clk);
    ptr_ld = 1'b1; ptr_ld_sel = 2'd1; ptr_ld_val = 12'h100;
    instr_valid = 1'b1; instr = 16'hE845;
    @(negedge clk);
    ptr_ld = 1'b0; instr_valid = 1'b0;
    chk("R9 load wins", ptr_o[23:12], 12'h100);
    @(negedge clk);
    ptr_ld = 1'b1; ptr_ld_sel = 2'd3; ptr_ld_val = 12'hABC;
    @(negedge clk);
    ptr_ld = 1'b0;
    chk("R9 sel3 ignored", ptr_o, {12'h000, 12'h100, 12'h100});

    // R8 valid low ignored
    @(negedge clk);
    instr = 16'hFA77;
    @(negedge clk);
    chk("R8 invalid no write", mem_we, 1'b0);
    chk("R8 invalid ptrs", ptr_o, {12'h000, 12'h100, 12'h100});

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset clears", ptr_o, 36'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule